// File: doc/BRIEF.md
# Video Memory Arbiter with Page Flipping

This block shares one 64K-word, 16-bit video memory between three requesters: the display refresh engine, which fetches pixel words for scan-out, the graphics controller, which reads and writes while drawing, and the host CPU, which reaches the memory directly through its bus interface. In any clock slot at most one requester drives the memory. The winner's address, write enable and write data go out on the memory command port in the same cycle as its grant. The synchronous memory returns read data one cycle later, and the block routes that data back to the requester that asked for it.

When automatic double buffering is enabled, the memory is split into two 32K-word pages selected by the top address bit. Display fetches are forced onto the visible page, named by a configuration bit. Every drawing access from the controller or the host is forced onto the other, hidden page. Toggling the page-select bit therefore swaps the two buffers. With double buffering off, all addresses pass through untouched and the page-select bit is ignored.

Host accesses have the lowest priority. A host request asserts the busy output until the access has been served. Busy falls in the cycle where the read word is on the host data output or the write has been committed. The host interface turns this busy output into its bus wait signal.

Top module: `vram_arbiter`

## Requirements
- R1: After synchronous reset, with no request asserted, all grants, `mem_en`, all three read-valid outputs and `host_busy` are 0.
- R2: Fixed priority: a display request always wins. A controller request wins when the display does not request. An eligible host request wins only when neither of the others requests. At most one grant is high in any cycle.
- R3: `mem_en` is high exactly when a grant is high. In that cycle, `mem_we` and `mem_wdata` come from the winner. A display grant always drives `mem_we` = 0.
- R4: With `cfg_dbuf_en` = 0, `mem_addr` equals the winner's 16-bit address unchanged, whatever the value of `cfg_show_hi`.
- R5: With `cfg_dbuf_en` = 1, a display grant drives `mem_addr[15]` = `cfg_show_hi` and keeps bits 14:0 of `disp_addr`.
- R6: With `cfg_dbuf_en` = 1, a controller or host grant drives `mem_addr[15]` = NOT `cfg_show_hi` and keeps bits 14:0 of its own address.
- R7: A granted read (any display grant, or a controller or host grant with write enable 0) raises only that requester's read-valid output in the next cycle. In that cycle `rd_data` equals the word the memory returns.
- R8: `host_busy` is high while `host_req` is high and the request has not yet been served. It falls in the cycle after the host grant and stays low until `host_req` drops. A held request is granted only once.
- R9: After a host read, `host_rdata` shows the returned word from the cycle in which busy falls until the next host read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dbuf_en | input | 1 | Automatic double buffering enable |
| cfg_show_hi | input | 1 | Visible page select (1 = upper page) |
| disp_req | input | 1 | Display fetch request for this cycle |
| disp_addr | input | 16 | Display fetch word address |
| gc_req | input | 1 | Controller access request for this cycle |
| gc_we | input | 1 | Controller write enable |
| gc_addr | input | 16 | Controller word address |
| gc_wdata | input | 16 | Controller write data |
| host_req | input | 1 | Host access request, held until served |
| host_we | input | 1 | Host write enable |
| host_addr | input | 16 | Host word address |
| host_wdata | input | 16 | Host write data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address after page steering |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the access |
| disp_gnt | output | 1 | Display granted this cycle |
| gc_gnt | output | 1 | Controller granted this cycle |
| host_gnt | output | 1 | Host granted this cycle |
| rd_data | output | 16 | Returned read word for display and controller |
| disp_rvalid | output | 1 | `rd_data` belongs to the display |
| gc_rvalid | output | 1 | `rd_data` belongs to the controller |
| host_rvalid | output | 1 | A host read word is on `host_rdata` this cycle |
| host_busy | output | 1 | Host must wait |
| host_rdata | output | 16 | Host read word, held |

## Verification
Grants, `mem_en`, the steered address, write enable and write data are combinational. They are due in the same cycle the requests are driven, so the bench drives inputs on the falling edge and samples one nanosecond before the next rising edge. Read-valid flags, `rd_data` and the fall of `host_busy` are due one rising edge after the grant. The bench keeps the expected winner, its steered address and the host-served flag from the previous slot and compares them in the following slot. `host_rdata` is compared every cycle against a held model value that is updated only when a modelled host read returns.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    localparam int VRAM_AW  = 16;
    localparam int VRAM_DW  = 16;
    localparam int NUM_SRC  = 3;

    // Requester slots, ordered by priority (index 0 wins)
    localparam int SLOT_DISP = 0;
    localparam int SLOT_GC   = 1;
    localparam int SLOT_HOST = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DISP = 2'd1,
        SRC_GC   = 2'd2,
        SRC_HOST = 2'd3
    } src_e;

    // Page bit after double-buffer steering
    function automatic logic page_bit(input logic dbuf_en,
                                      input logic show_hi,
                                      input logic is_display,
                                      input logic orig);
        if (!dbuf_en)
            return orig;
        return is_display ? show_hi : ~show_hi;
    endfunction

    // Owner of the data returning next cycle, or SRC_NONE for writes/idle
    function automatic src_e read_owner(input logic [NUM_SRC-1:0] gnt,
                                        input logic gc_we,
                                        input logic host_we);
        if (gnt[SLOT_DISP])
            return SRC_DISP;
        if (gnt[SLOT_GC] && !gc_we)
            return SRC_GC;
        if (gnt[SLOT_HOST] && !host_we)
            return SRC_HOST;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/vram_arb_pick.sv
module vram_arb_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_top
            assign gnt[i] = req[i];
        end else begin : g_lower
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
        end
    end

endmodule

// File: rtl/vram_page_steer.sv
module vram_page_steer
    import vram_arb_pkg::*;
#(
    parameter int AW         = 16,
    parameter bit IS_DISPLAY = 1'b0
) (
    input  logic [AW-1:0] addr_in,
    input  logic          dbuf_en,
    input  logic          show_hi,
    output logic [AW-1:0] addr_out
);

    assign addr_out = {page_bit(dbuf_en, show_hi, IS_DISPLAY, addr_in[AW-1]),
                       addr_in[AW-2:0]};

endmodule

// File: rtl/vram_arb_return.sv
module vram_arb_return
    import vram_arb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] gnt,
    input  logic               gc_we,
    input  logic               host_we,
    input  logic               host_req,
    input  logic [DW-1:0]      mem_rdata,
    output logic               disp_rvalid,
    output logic               gc_rvalid,
    output logic               host_rvalid,
    output logic               host_done,
    output logic [DW-1:0]      host_rdata
);

    src_e          ret_owner;
    logic [DW-1:0] host_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_owner <= SRC_NONE;
            host_done <= 1'b0;
            host_hold <= '0;
        end else begin
            ret_owner <= read_owner(gnt, gc_we, host_we);
            if (gnt[SLOT_HOST])
                host_done <= 1'b1;
            else if (!host_req)
                host_done <= 1'b0;
            if (ret_owner == SRC_HOST)
                host_hold <= mem_rdata;
        end
    end

    assign disp_rvalid = (ret_owner == SRC_DISP);
    assign gc_rvalid   = (ret_owner == SRC_GC);
    assign host_rvalid = (ret_owner == SRC_HOST);
    assign host_rdata  = host_rvalid ? mem_rdata : host_hold;

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({disp_rvalid, gc_rvalid, host_rvalid})); // R7
    AST_GC_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (gnt[SLOT_GC] && !gc_we) |=> gc_rvalid); // R7
    AST_WRITE_NO_RETURN: assert property (@(posedge clk) disable iff (rst)
        (gnt[SLOT_HOST] && host_we) |=> !host_rvalid); // R7

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
    import vram_arb_pkg::*;
#(
    parameter int AW = VRAM_AW,
    parameter int DW = VRAM_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_dbuf_en,
    input  logic          cfg_show_hi,
    input  logic          disp_req,
    input  logic [AW-1:0] disp_addr,
    input  logic          gc_req,
    input  logic          gc_we,
    input  logic [AW-1:0] gc_addr,
    input  logic [DW-1:0] gc_wdata,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          disp_gnt,
    output logic          gc_gnt,
    output logic          host_gnt,
    output logic [DW-1:0] rd_data,
    output logic          disp_rvalid,
    output logic          gc_rvalid,
    output logic          host_rvalid,
    output logic          host_busy,
    output logic [DW-1:0] host_rdata
);

    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] gnt;
    logic [AW-1:0]      raw_addr [NUM_SRC];
    logic [AW-1:0]      stv_addr [NUM_SRC];
    logic               host_done;

    assign raw_addr[SLOT_DISP] = disp_addr;
    assign raw_addr[SLOT_GC]   = gc_addr;
    assign raw_addr[SLOT_HOST] = host_addr;

    assign elig[SLOT_DISP] = disp_req;
    assign elig[SLOT_GC]   = gc_req;
    assign elig[SLOT_HOST] = host_req & ~host_done;

    vram_arb_pick #(.N(NUM_SRC)) i_pick (
        .req (elig),
        .gnt (gnt)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_steer
        vram_page_steer #(
            .AW         (AW),
            .IS_DISPLAY (s == SLOT_DISP)
        ) i_steer (
            .addr_in  (raw_addr[s]),
            .dbuf_en  (cfg_dbuf_en),
            .show_hi  (cfg_show_hi),
            .addr_out (stv_addr[s])
        );
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (gnt[SLOT_DISP]) begin
            mem_en   = 1'b1;
            mem_addr = stv_addr[SLOT_DISP];
        end else if (gnt[SLOT_GC]) begin
            mem_en    = 1'b1;
            mem_we    = gc_we;
            mem_addr  = stv_addr[SLOT_GC];
            mem_wdata = gc_wdata;
        end else if (gnt[SLOT_HOST]) begin
            mem_en    = 1'b1;
            mem_we    = host_we;
            mem_addr  = stv_addr[SLOT_HOST];
            mem_wdata = host_wdata;
        end
    end

    vram_arb_return #(.DW(DW)) i_ret (
        .clk         (clk),
        .rst         (rst),
        .gnt         (gnt),
        .gc_we       (gc_we),
        .host_we     (host_we),
        .host_req    (host_req),
        .mem_rdata   (mem_rdata),
        .disp_rvalid (disp_rvalid),
        .gc_rvalid   (gc_rvalid),
        .host_rvalid (host_rvalid),
        .host_done   (host_done),
        .host_rdata  (host_rdata)
    );

    assign disp_gnt  = gnt[SLOT_DISP];
    assign gc_gnt    = gnt[SLOT_GC];
    assign host_gnt  = gnt[SLOT_HOST];
    assign rd_data   = mem_rdata;
    assign host_busy = host_req & ~host_done;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({disp_gnt, gc_gnt, host_gnt})); // R2
    AST_DISP_WINS: assert property (@(posedge clk) disable iff (rst)
        disp_req |-> disp_gnt); // R2
    AST_GC_OVER_HOST: assert property (@(posedge clk) disable iff (rst)
        (gc_req && !disp_req) |-> (gc_gnt && !host_gnt)); // R2
    AST_DISP_READS: assert property (@(posedge clk) disable iff (rst)
        disp_gnt |-> (mem_en && !mem_we)); // R3
    AST_PLAIN_ADDR: assert property (@(posedge clk) disable iff (rst)
        (gc_gnt && !cfg_dbuf_en) |-> (mem_addr == gc_addr)); // R4
    AST_VISIBLE_PAGE: assert property (@(posedge clk) disable iff (rst)
        (disp_gnt && cfg_dbuf_en) |-> (mem_addr[AW-1] == cfg_show_hi)); // R5
    AST_HIDDEN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (host_gnt && cfg_dbuf_en) |-> (mem_addr[AW-1] != cfg_show_hi)); // R6
    AST_DISP_RETURN: assert property (@(posedge clk) disable iff (rst)
        disp_gnt |=> disp_rvalid); // R7
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        host_gnt |=> !host_busy); // R8
    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (rst)
        host_gnt |=> !host_gnt); // R8

endmodule

// File: tb/test_vram_arbiter.sv
module test_vram_arbiter;

    localparam logic [15:0] KEY = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_dbuf_en, cfg_show_hi;
    logic        disp_req, gc_req, gc_we, host_req, host_we;
    logic [15:0] disp_addr, gc_addr, gc_wdata, host_addr, host_wdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        disp_gnt, gc_gnt, host_gnt;
    logic [15:0] rd_data, host_rdata;
    logic        disp_rvalid, gc_rvalid, host_rvalid, host_busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_run = 1'b0;

    always #2 clk = ~clk;

    // Synchronous memory stand-in: returns a keyed copy of the address
    always_ff @(posedge clk) mem_rdata <= mem_addr ^ KEY;

    vram_arbiter i_vram_arbiter (
        .clk(clk), .rst(rst), .cfg_dbuf_en(cfg_dbuf_en), .cfg_show_hi(cfg_show_hi),
        .disp_req(disp_req), .disp_addr(disp_addr),
        .gc_req(gc_req), .gc_we(gc_we), .gc_addr(gc_addr), .gc_wdata(gc_wdata),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .disp_gnt(disp_gnt), .gc_gnt(gc_gnt), .host_gnt(host_gnt),
        .rd_data(rd_data), .disp_rvalid(disp_rvalid), .gc_rvalid(gc_rvalid),
        .host_rvalid(host_rvalid), .host_busy(host_busy), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] steer(input logic [15:0] a, input logic dbuf,
                                          input logic show, input logic is_disp);
        if (!dbuf) return a;
        return {is_disp ? show : ~show, a[14:0]};
    endfunction

    // Model state
    int          m_prev_win;   // 0 none, 1 disp, 2 gc, 3 host (reads only)
    logic [15:0] m_prev_addr;
    logic        m_done;
    logic [15:0] m_hold;
    bit          release_seen;

    initial begin
        rst = 1'b1;
        {cfg_dbuf_en, cfg_show_hi, disp_req, gc_req, gc_we, host_req, host_we} = '0;
        {disp_addr, gc_addr, gc_wdata, host_addr, host_wdata} = '0;
        void'($urandom(32'h1234_5678));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "grants after reset", {disp_gnt, gc_gnt, host_gnt}, 0);
        chk("R1", "mem_en after reset", mem_en, 0);
        chk("R1", "rvalids after reset", {disp_rvalid, gc_rvalid, host_rvalid}, 0);
        chk("R1", "busy after reset", host_busy, 0);

        m_prev_win = 0; m_prev_addr = '0; m_done = 1'b0; m_hold = '0;
        release_seen = 1'b0;

        for (int cyc = 0; cyc < 4000; cyc++) begin
            int          win;
            logic [15:0] e_addr, e_wdata;
            logic        e_we, e_busy;
            @(negedge clk);
            // configuration: directed phases first, then random changes
            if (cyc < 300) begin
                cfg_dbuf_en = 1'b0;
                cfg_show_hi = cyc[4];
            end else if (cyc % 50 == 0) begin
                cfg_dbuf_en = 1'($urandom);
                cfg_show_hi = 1'($urandom);
            end
            disp_req  = (cyc < 40) ? 1'b1 : ($urandom % 3 == 0);
            disp_addr = 16'($urandom);
            gc_req    = ($urandom % 3 == 0);
            gc_we     = 1'($urandom);
            gc_addr   = 16'($urandom);
            gc_wdata  = 16'($urandom);
            if (host_req && release_seen) begin
                host_req = 1'b0;
            end else if (!host_req && ($urandom % 3 == 0)) begin
                host_req   = 1'b1;
                host_we    = 1'($urandom);
                host_addr  = 16'($urandom);
                host_wdata = 16'($urandom);
            end
            #1;
            // expected winner this slot
            if (disp_req) win = 1;
            else if (gc_req) win = 2;
            else if (host_req && !m_done) win = 3;
            else win = 0;
            e_we = 1'b0; e_addr = '0; e_wdata = '0;
            case (win)
                1: e_addr = steer(disp_addr, cfg_dbuf_en, cfg_show_hi, 1'b1);
                2: begin e_addr = steer(gc_addr, cfg_dbuf_en, cfg_show_hi, 1'b0);
                         e_we = gc_we; e_wdata = gc_wdata; end
                3: begin e_addr = steer(host_addr, cfg_dbuf_en, cfg_show_hi, 1'b0);
                         e_we = host_we; e_wdata = host_wdata; end
                default: ;
            endcase
            chk("R2", "grant vector", {host_gnt, gc_gnt, disp_gnt},
                {29'd0, win == 3, win == 2, win == 1});
            chk("R3", "mem_en", mem_en, win != 0);
            if (win != 0) begin
                chk("R3", "mem_we", mem_we, e_we);
                if (e_we) chk("R3", "mem_wdata", mem_wdata, e_wdata);
                if (!cfg_dbuf_en) chk("R4", "plain address", mem_addr, e_addr);
                else if (win == 1) chk("R5", "visible page address", mem_addr, e_addr);
                else chk("R6", "hidden page address", mem_addr, e_addr);
            end
            chk("R7", "rvalid vector", {host_rvalid, gc_rvalid, disp_rvalid},
                {29'd0, m_prev_win == 3, m_prev_win == 2, m_prev_win == 1});
            if (m_prev_win == 1 || m_prev_win == 2)
                chk("R7", "rd_data", rd_data, m_prev_addr ^ KEY);
            if (m_prev_win == 3) m_hold = m_prev_addr ^ KEY;
            e_busy = host_req && !m_done;
            chk("R8", "host_busy", host_busy, e_busy);
            chk("R9", "host_rdata", host_rdata, m_hold);
            release_seen = host_req && !host_busy;
            // model state advance at the coming rising edge
            m_prev_win  = (win == 1 || (win != 0 && !e_we)) ? win : 0;
            m_prev_addr = e_addr;
            if (win == 3) m_done = 1'b1;
            else if (!host_req) m_done = 1'b0;
        end
        done_run = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule